// File: doc/BRIEF.md
# Converter channel power sequencer

This block sits on the host side of a multi-channel converter. It powers the converter's output channels up and down by issuing 24-bit control-register write frames to an SPI master. For each channel it keeps a shadow copy of the channel control word. It also keeps a power-down mask with one bit per channel, where 1 means powered down.

A request names a channel and the wanted state. If the request matches the channel's mask bit, nothing is sent. Power-down is one frame that clears all three enable bits at once. Power-up takes two frames in a fixed order:

1. The first frame sets the internal-enable and DC-DC enable bits.
2. The block then waits a settling delay, counted in clock cycles from a clock-frequency parameter.
3. The second frame adds output enable.

While a sequence runs, `busy_o` is high and new requests are ignored. Each frame is held on the output until the SPI master takes it.

Top module: `chan_pwr_seq`

## Requirements
- R1: After reset `pd_mask_o` is all ones, `busy_o` is low and `frame_valid_o` is low.
- R2: A request whose off flag equals the channel's current mask bit issues no frame, leaves `busy_o` low and leaves the mask unchanged.
- R3: A power-up request (`req_off_i`=0) clears the channel's mask bit at the clock edge that accepts it. The first frame carries the shadow word with bit 8 (internal enable) and bit 4 (DC-DC enable) set.
- R4: After the first power-up frame is accepted, the block waits SETTLE_US microseconds (CLK_HZ/1e6*SETTLE_US cycles) before raising the second frame. With ready held high, the two handshakes are exactly that count plus one cycles apart.
- R5: The second power-up frame carries the shadow word with bit 6 (output enable) added to the bits already set.
- R6: A power-down request (`req_off_i`=1) sets the mask bit at the accepting edge. It issues exactly one frame whose word has bits 8, 6 and 4 cleared.
- R7: Every frame has the following layout: bits 23:21 are zero; bits 20:16 hold 0x1C plus the channel index; bits 15:13 hold 2; bits 12:0 hold the shadow word.
- R8: `busy_o` stays high from the accepting edge until the last frame of the sequence is accepted. Requests presented while it is high are ignored: they produce no frame and no mask change.
- R9: While `frame_valid_o` is high and `frame_ready_i` is low, the valid flag and `frame_o` hold steady.
- R10: Each channel has its own shadow word, so a sequence on one channel never carries enable bits belonging to another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Power request strobe |
| req_chan_i | input | $clog2(NUM_CH) | Channel index of the request |
| req_off_i | input | 1 | 1 = power down, 0 = power up |
| frame_o | output | 24 | Write frame to the SPI master |
| frame_valid_o | output | 1 | Frame is present |
| frame_ready_i | input | 1 | SPI master takes the frame |
| busy_o | output | 1 | A sequence is in progress |
| pd_mask_o | output | NUM_CH | Power-down mask, 1 = channel down |

## Verification
The assertions assume the SPI master only raises ready for a frame it will take in that cycle. They also assume requests come from a single source that honours `busy_o`. The bench drives ready either held high or stalling two of every three cycles. This exercises frame holding without ever dropping a valid frame. The bench raises requests for one cycle, sometimes deliberately while busy, to show they are ignored. It shortens the settling count through the clock-frequency parameter, so the cycle count can be measured exactly.

// File: rtl/chan_pwr_seq_pkg.sv
package chan_pwr_seq_pkg;
  localparam int FRAME_W = 24;
  localparam int WORD_W  = 13;
  localparam logic [4:0] CTRL_ADDR_BASE = 5'h1C;
  localparam logic [2:0] SEL_DAC_CTRL   = 3'd2;
  localparam int BIT_INT_EN  = 8;
  localparam int BIT_OUT_EN  = 6;
  localparam int BIT_DCDC_EN = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND1, ST_SETTLE, ST_SEND2} seq_state_e;

  function automatic logic [FRAME_W-1:0] build_frame(input logic [4:0] addr,
                                                     input logic [WORD_W-1:0] word);
    return {3'b000, addr, SEL_DAC_CTRL, word};
  endfunction
endpackage

// File: rtl/chan_pwr_seq_timer.sv
module chan_pwr_seq_timer #(
  parameter int unsigned CYCLES = 40000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int unsigned LIM = (CYCLES > 0) ? CYCLES - 1 : 0;
  localparam int CW = (LIM > 0) ? $clog2(LIM + 1) : 1;

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign done_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= CW'(LIM);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R4
endmodule

// File: rtl/chan_pwr_seq_shadow.sv
module chan_pwr_seq_shadow
  import chan_pwr_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CHW-1:0]    wr_ch_i,
  input  logic [WORD_W-1:0] set_i,
  input  logic [WORD_W-1:0] clr_i,
  input  logic              mask_we_i,
  input  logic              mask_val_i,
  input  logic [CHW-1:0]    rd_ch_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [NUM_CH-1:0] mask_o
);
  logic [WORD_W-1:0] word_q [NUM_CH];
  logic [NUM_CH-1:0] mask_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        word_q[g] <= '0;
        mask_q[g] <= 1'b1;
      end else begin
        if (we_i && wr_ch_i == CHW'(g)) word_q[g] <= (word_q[g] | set_i) & ~clr_i;
        if (mask_we_i && wr_ch_i == CHW'(g)) mask_q[g] <= mask_val_i;
      end
    end
  end

  assign rd_word_o = word_q[rd_ch_i];
  assign mask_o    = mask_q;
endmodule

// File: rtl/chan_pwr_seq.sv
module chan_pwr_seq
  import chan_pwr_seq_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CLK_HZ    = 200_000_000,
  parameter int SETTLE_US = 200,
  localparam int CHW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [CHW-1:0]     req_chan_i,
  input  logic               req_off_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               frame_valid_o,
  input  logic               frame_ready_i,
  output logic               busy_o,
  output logic [NUM_CH-1:0]  pd_mask_o
);
  localparam logic [WORD_W-1:0] M_INT  = WORD_W'(1) << BIT_INT_EN;
  localparam logic [WORD_W-1:0] M_OUT  = WORD_W'(1) << BIT_OUT_EN;
  localparam logic [WORD_W-1:0] M_DCDC = WORD_W'(1) << BIT_DCDC_EN;

  seq_state_e        state_q;
  logic [CHW-1:0]    ch_q;
  logic              up_q;
  logic              start, hs, settle_done, tmr_load;
  logic              sh_we;
  logic [CHW-1:0]    sh_ch;
  logic [WORD_W-1:0] sh_set, sh_clr, rd_word;

  assign start = req_valid_i && (state_q == ST_IDLE) && (pd_mask_o[req_chan_i] != req_off_i);
  assign hs    = frame_valid_o && frame_ready_i;
  assign tmr_load = (state_q == ST_SEND1) && hs && up_q;

  always_comb begin
    sh_we  = 1'b0;
    sh_ch  = ch_q;
    sh_set = '0;
    sh_clr = '0;
    if (start) begin
      sh_we = 1'b1;
      sh_ch = req_chan_i;
      if (req_off_i) sh_clr = M_INT | M_OUT | M_DCDC;
      else           sh_set = M_INT | M_DCDC;
    end else if (state_q == ST_SETTLE && settle_done) begin
      sh_we  = 1'b1;
      sh_set = M_OUT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ch_q    <= '0;
      up_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_SEND1;
          ch_q    <= req_chan_i;
          up_q    <= !req_off_i;
        end
        ST_SEND1:  if (hs) state_q <= up_q ? ST_SETTLE : ST_IDLE;
        ST_SETTLE: if (settle_done) state_q <= ST_SEND2;
        ST_SEND2:  if (hs) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  chan_pwr_seq_shadow #(.NUM_CH(NUM_CH)) u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (sh_we),
    .wr_ch_i    (sh_ch),
    .set_i      (sh_set),
    .clr_i      (sh_clr),
    .mask_we_i  (start),
    .mask_val_i (req_off_i),
    .rd_ch_i    (ch_q),
    .rd_word_o  (rd_word),
    .mask_o     (pd_mask_o)
  );

  chan_pwr_seq_timer #(.CYCLES(SETTLE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .done_o (settle_done)
  );

  assign frame_valid_o = (state_q == ST_SEND1) || (state_q == ST_SEND2);
  assign frame_o       = build_frame(CTRL_ADDR_BASE | 5'(ch_q), rd_word);
  assign busy_o        = (state_q != ST_IDLE);

  AST_FRAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o && !frame_ready_i |=> frame_valid_o && $stable(frame_o)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !frame_valid_o); // R2
  AST_MASK_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> $stable(pd_mask_o)); // R8
  AST_OUT_NEEDS_INT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o && frame_o[BIT_OUT_EN] |-> frame_o[BIT_INT_EN]); // R5
  AST_FRAME_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> frame_o[15:13] == SEL_DAC_CTRL && frame_o[23:21] == 3'b000); // R7
endmodule

// File: tb/chan_pwr_seq_tb.sv
module chan_pwr_seq_tb;
  localparam int NUM_CH = 4;
  localparam int CLK_HZ = 1_000_000;
  localparam int SETTLE_US = 20;
  localparam int S = 20;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_off = 0, ready = 1, stall = 0;
  logic [1:0] req_ch = 0;
  logic [23:0] frame;
  logic frame_valid, busy;
  logic [3:0] mask;
  int total = 0, bad = 0, cyc = 0;

  logic [23:0] exp_q[$];
  int hs_q[$];
  logic [12:0] m_word [4];
  logic [3:0] m_mask;

  always #2.5 clk = ~clk;

  chan_pwr_seq #(.NUM_CH(NUM_CH), .CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_chan_i(req_ch),
    .req_off_i(req_off), .frame_o(frame), .frame_valid_o(frame_valid),
    .frame_ready_i(ready), .busy_o(busy), .pd_mask_o(mask));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(input int ch, input logic [12:0] w);
    return {3'b000, 5'(5'h1C + ch), 3'd2, w};
  endfunction

  initial forever begin
    @(posedge clk);
    cyc++;
    #1 ready = stall ? (cyc % 3 == 0) : 1'b1;
  end

  // monitor
  initial begin
    logic held = 0;
    logic [23:0] held_f = 0;
    forever begin
      @(negedge clk);
      if (held) check(frame_valid && frame == held_f, "R9 hold", frame, held_f);
      held = frame_valid && !ready;
      held_f = frame;
      if (frame_valid && ready) begin
        hs_q.push_back(cyc + 1);
        if (exp_q.size() == 0) check(0, "R8 unexpected frame", frame, 0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          check(frame == e, "R7 frame", frame, e);
        end
      end
    end
  end

  initial begin
    #(5ns * 150000);
    check(0, "R4 watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic wait_idle();
    do @(negedge clk); while (busy || exp_q.size() != 0);
  endtask

  task automatic pulse(input int ch, input bit off);
    @(negedge clk);
    req_valid = 1; req_ch = 2'(ch); req_off = off;
    @(posedge clk);
    #1 req_valid = 0;
  endtask

  task automatic request(input int ch, input bit off);
    bit match;
    match = (m_mask[ch] == off);
    hs_q.delete();
    if (!match) begin
      m_mask[ch] = off;
      if (off) begin
        m_word[ch] &= ~13'h150;
        exp_q.push_back(mk(ch, m_word[ch]));
      end else begin
        m_word[ch] |= 13'h110;
        exp_q.push_back(mk(ch, m_word[ch]));
        m_word[ch] |= 13'h040;
        exp_q.push_back(mk(ch, m_word[ch]));
      end
    end
    pulse(ch, off);
    @(negedge clk);
    if (match) begin
      check(!busy && !frame_valid, "R2 no traffic", {busy, frame_valid}, 0);
      check(mask == m_mask, "R2 mask", mask, m_mask);
    end else begin
      check(busy, "R8 busy", busy, 1);
      check(mask == m_mask, off ? "R6 early mask" : "R3 early mask", mask, m_mask);
    end
  endtask

  initial begin
    m_mask = 4'hF;
    for (int i = 0; i < 4; i++) m_word[i] = '0;
    #12 rst_n = 1;
    @(negedge clk);
    check(mask == 4'hF, "R1 mask", mask, 4'hF);
    check(!busy && !frame_valid, "R1 idle", {busy, frame_valid}, 0);

    // R3 R4 R5: power up ch0, ready high
    request(0, 0);
    wait_idle();
    check(hs_q.size() == 2, "R5 two frames", hs_q.size(), 2);
    if (hs_q.size() == 2) check(hs_q[1] - hs_q[0] == S + 1, "R4 gap", hs_q[1] - hs_q[0], S + 1);

    // R2: already up
    request(0, 0);
    repeat (3) @(negedge clk);
    check(!frame_valid, "R2 quiet", frame_valid, 0);

    // R9 R10 R8: ch2 up with stalls, intrusion while busy
    stall = 1;
    request(2, 0);
    pulse(3, 0);
    wait_idle();
    check(mask == m_mask, "R8 ignored request", mask, m_mask);
    check(hs_q.size() == 2, "R10 frames", hs_q.size(), 2);
    if (hs_q.size() == 2) check(hs_q[1] - hs_q[0] >= S + 1, "R4 gap stalled", hs_q[1] - hs_q[0], S + 1);

    // R6: power down ch0, single frame
    stall = 0;
    request(0, 1);
    wait_idle();
    check(hs_q.size() == 1, "R6 single frame", hs_q.size(), 1);
    check(mask == 4'b1011, "R6 mask", mask, 4'b1011);

    // R2: ch3 already down
    request(3, 1);

    // ch3 up and down under stalls
    stall = 1;
    request(3, 0);
    wait_idle();
    request(3, 1);
    wait_idle();
    check(mask == 4'b1011, "R6 final mask", mask, 4'b1011);
    check(exp_q.size() == 0, "R7 all frames seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule